// File: doc/BRIEF.md
# Sector Erase Queue with Acceptance Window

This block gathers the sectors a host selects for erasure after a sector erase command sequence. Each select strobe carries a sector index and sets one bit of a per-sector mask. The first accepted strobe opens an acceptance window, and every further accepted strobe restarts it. The window length is a parameter counted in clock cycles. While the window is open, an abort strobe empties the queue and returns the block to idle.

When the window runs out, the block takes a snapshot of the selected sectors that are not protected. It then hands them to an erase engine one at a time through a request/done handshake, lowest index first. Protected sectors are dropped without any report. If every selected sector is protected, the block stays busy for a fixed hold delay and then goes idle without asking for any erase. After expiry, a status bit stays high until the block is idle again. The busy flag covers the whole time from the first accepted strobe to the return to idle.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset, busy, windowExpired and engReq are all 0.
- R2: A select strobe whose index is below NUM_SECTORS, seen in idle, makes busy 1 at the next edge with windowExpired 0. windowExpired rises at the edge WINDOW_CYCLES cycles after the edge that sampled the last accepted strobe.
- R3: Each accepted strobe while the window is open adds its sector and restarts the full window, so the window can stay open longer than WINDOW_CYCLES after the first strobe.
- R4: Any number of sectors, up to all NUM_SECTORS, may be queued in any order. A strobe with an index of NUM_SECTORS or more has no effect in idle or in the window.
- R5: After expiry, engReq is 1 and engSector gives the lowest pending index. A cycle with engDone high retires that sector, and the next pending index is presented in the following cycle.
- R6: protMask bit i = 1 marks sector i as protected. The mask is sampled at the expiry edge, and protected sectors are never presented on engSector.
- R7: If every selected sector is protected, engReq stays 0, and busy falls at the edge HOLD_CYCLES cycles after the expiry edge.
- R8: windowExpired stays 1 from the expiry edge until the block returns to idle, and it is 0 whenever busy is 0.
- R9: An abort strobe while the window is open empties the queue, and busy is 0 at the next edge. If abort and select occur in the same cycle, abort wins.
- R10: After expiry, abort and select strobes are ignored: engReq and engSector are unchanged, and the ignored sector is not erased by the next queue.
- R11: The mask is empty after the last sector is retired, after an abort and after reset. A later queue erases only its own sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selStrobe | input | 1 | One-cycle request to add a sector to the queue |
| selIdx | input | IDX_W | Sector index for selStrobe |
| abortStrobe | input | 1 | Any other command during the window; empties the queue |
| protMask | input | NUM_SECTORS | Protection mask, bit i = 1 marks sector i as protected |
| engDone | input | 1 | Erase engine has finished the sector presented |
| engReq | output | 1 | A sector is presented to the erase engine |
| engSector | output | IDX_W | Index of the sector presented |
| windowExpired | output | 1 | Acceptance window has closed and erasure has started |
| busy | output | 1 | Queue is not idle |

## Verification
On every cycle, the assertions check these invariants: the pending set stays a subset of the selected mask, the presented index is actually pending, each engine completion retires exactly one sector, and the mask is empty whenever the block is idle. They also check that an abort in the window leads to idle, and that the window closes once its count is spent. Only the bench scenarios can show the end-to-end effects. These are the exact expiry edge after a chain of restarts, the lowest-index-first order across a full queue, the silent removal of protected sectors, the length of the all-protected hold, and that strobes ignored during erasure leave no trace in the next queue.

// File: rtl/erq_pkg.sv
package erq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2,
    ST_HOLD   = 2'd3
  } qState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addSel;    // set the bit of selIdx in the select mask
    logic clearAll;  // empty select and pending masks
    logic loadWin;   // reload the window counter
    logic loadHold;  // load the all-protected hold counter
    logic decCnt;    // count down
    logic capture;   // snapshot selected and unprotected sectors
    logic retire;    // drop the presented sector from the pending set
  } dpCmd_t;
endpackage

// File: rtl/erq_datapath.sv
module erq_datapath
  import erq_pkg::*;
#(
  parameter int NUM_SECTORS = 19,
  parameter int IDX_W       = 5,
  parameter int CNT_W       = 14,
  parameter int WIN_LOAD    = 7,
  parameter int HOLD_LOAD   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCmd_t                 cmd,
  input  logic [IDX_W-1:0]       selIdx,
  input  logic [NUM_SECTORS-1:0] protMask,
  output logic                   cntZero,
  output logic                   effEmpty,
  output logic                   pendLast,
  output logic                   maskEmpty,
  output logic [IDX_W-1:0]       curIdx
);
  logic [NUM_SECTORS-1:0] selMask;
  logic [NUM_SECTORS-1:0] pendMask;
  logic [NUM_SECTORS-1:0] curBit;
  logic [CNT_W-1:0]       cnt;

  localparam int MAX_LOAD = (WIN_LOAD > HOLD_LOAD) ? WIN_LOAD : HOLD_LOAD;

  // lowest pending index wins
  always_comb begin
    curIdx = '0;
    for (int i = NUM_SECTORS - 1; i >= 0; i--) begin
      if (pendMask[i]) curIdx = IDX_W'(i);
    end
  end

  assign curBit    = NUM_SECTORS'(1) << curIdx;
  assign cntZero   = (cnt == '0);
  assign effEmpty  = ((selMask & ~protMask) == '0);
  assign pendLast  = ((pendMask & ~curBit) == '0);
  assign maskEmpty = (selMask == '0) && (pendMask == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selMask <= '0;
    end else if (cmd.clearAll) begin
      selMask <= '0;
    end else if (cmd.addSel) begin
      selMask <= selMask | (NUM_SECTORS'(1) << selIdx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
    end else if (cmd.clearAll) begin
      pendMask <= '0;
    end else if (cmd.capture) begin
      pendMask <= selMask & ~protMask;
    end else if (cmd.retire) begin
      pendMask <= pendMask & ~curBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.loadWin) begin
      cnt <= CNT_W'(WIN_LOAD);
    end else if (cmd.loadHold) begin
      cnt <= CNT_W'(HOLD_LOAD);
    end else if (cmd.decCnt && !cntZero) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R6 / R11: pending work is always drawn from the selection
  p_pend_subset_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendMask & ~selMask) == '0);

  // R5: the presented index is a pending sector
  p_cur_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendMask != '0) |-> pendMask[curIdx]);

  // R5: one completion retires exactly one sector
  p_retire_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.retire && !cmd.clearAll && pendMask != '0) |=>
      $countones(pendMask) == $countones($past(pendMask)) - 1);

  p_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) <= MAX_LOAD);
endmodule

// File: rtl/erq_control.sv
module erq_control
  import erq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   selStrobe,
  input  logic   selValid,
  input  logic   abortStrobe,
  input  logic   engDone,
  input  logic   cntZero,
  input  logic   effEmpty,
  input  logic   pendLast,
  output dpCmd_t cmd,
  output logic   engReq,
  output logic   windowExpired,
  output logic   busy
);
  qState_t state, nextState;
  logic    addOk;

  assign addOk = selStrobe && selValid;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (addOk) begin
          cmd.addSel  = 1'b1;
          cmd.loadWin = 1'b1;
          nextState   = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (abortStrobe) begin
          cmd.clearAll = 1'b1;
          nextState    = ST_IDLE;
        end else if (addOk) begin
          cmd.addSel  = 1'b1;
          cmd.loadWin = 1'b1;
        end else if (cntZero) begin
          if (effEmpty) begin
            cmd.loadHold = 1'b1;
            nextState    = ST_HOLD;
          end else begin
            cmd.capture = 1'b1;
            nextState   = ST_ERASE;
          end
        end else begin
          cmd.decCnt = 1'b1;
        end
      end
      ST_ERASE: begin
        if (engDone) begin
          cmd.retire = 1'b1;
          if (pendLast) begin
            cmd.clearAll = 1'b1;
            nextState    = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          cmd.clearAll = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          cmd.decCnt = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign engReq        = (state == ST_ERASE);
  assign windowExpired = (state == ST_ERASE) || (state == ST_HOLD);
  assign busy          = (state != ST_IDLE);

  // R2: an accepted strobe in idle opens the window
  p_open_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && addOk) |=> (busy && !windowExpired));

  // R2: a spent window closes unless a strobe arrives
  p_window_close_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && cntZero && !selStrobe && !abortStrobe) |=> windowExpired);

  // R9: abort in the window returns to idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && abortStrobe) |=> !busy);

  // R10: strobes do not disturb an erase in progress
  p_erase_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && !engDone) |=> engReq);
endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue
  import erq_pkg::*;
#(
  parameter int NUM_SECTORS   = 19,
  parameter int WINDOW_CYCLES = 6250,
  parameter int HOLD_CYCLES   = 12500,
  localparam int IDX_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int MAX_CNT      = (WINDOW_CYCLES > HOLD_CYCLES) ? WINDOW_CYCLES : HOLD_CYCLES,
  localparam int CNT_W        = $clog2(MAX_CNT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   selStrobe,
  input  logic [IDX_W-1:0]       selIdx,
  input  logic                   abortStrobe,
  input  logic [NUM_SECTORS-1:0] protMask,
  input  logic                   engDone,
  output logic                   engReq,
  output logic [IDX_W-1:0]       engSector,
  output logic                   windowExpired,
  output logic                   busy
);
  dpCmd_t cmd;
  logic   cntZero, effEmpty, pendLast, maskEmpty, selValid;

  assign selValid = ({1'b0, selIdx} < (IDX_W + 1)'(NUM_SECTORS));

  erq_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .selStrobe    (selStrobe),
    .selValid     (selValid),
    .abortStrobe  (abortStrobe),
    .engDone      (engDone),
    .cntZero      (cntZero),
    .effEmpty     (effEmpty),
    .pendLast     (pendLast),
    .cmd          (cmd),
    .engReq       (engReq),
    .windowExpired(windowExpired),
    .busy         (busy)
  );

  erq_datapath #(
    .NUM_SECTORS(NUM_SECTORS),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .WIN_LOAD   (WINDOW_CYCLES - 1),
    .HOLD_LOAD  (HOLD_CYCLES - 1)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .selIdx   (selIdx),
    .protMask (protMask),
    .cntZero  (cntZero),
    .effEmpty (effEmpty),
    .pendLast (pendLast),
    .maskEmpty(maskEmpty),
    .curIdx   (engSector)
  );

  // R11: an idle block carries no leftover selection
  p_idle_clean_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> maskEmpty);

  // R8: status only while busy
  p_status_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    windowExpired |-> busy);
endmodule

// File: tb/sector_erase_queue_tb.sv
module sector_erase_queue_tb;
  localparam int N   = 19;
  localparam int W   = 8;
  localparam int H   = 5;
  localparam int IW  = 5;
  localparam int GAP = W - 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selStrobe = 1'b0;
  logic [IW-1:0] selIdx = '0;
  logic          abortStrobe = 1'b0;
  logic [N-1:0]  protMask = '0;
  logic          engDone = 1'b0;
  logic          engReq;
  logic [IW-1:0] engSector;
  logic          windowExpired;
  logic          busy;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sector_erase_queue #(.NUM_SECTORS(N), .WINDOW_CYCLES(W), .HOLD_CYCLES(H)) u_dut (
    .clk(clk), .rstN(rstN), .selStrobe(selStrobe), .selIdx(selIdx),
    .abortStrobe(abortStrobe), .protMask(protMask), .engDone(engDone),
    .engReq(engReq), .engSector(engSector), .windowExpired(windowExpired), .busy(busy)
  );

  localparam logic [N-1:0] SEL_V  [4] = '{19'h00004, 19'h40011, 19'h00006, 19'h7FFFF};
  localparam logic [N-1:0] PROT_V [4] = '{19'h00000, 19'h00010, 19'h00006, 19'h00401};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int idx);
    selStrobe = 1'b1;
    selIdx    = IW'(idx);
    tick();
    selStrobe = 1'b0;
  endtask

  // service the engine for the lowest-first order of exp
  task automatic serve(input logic [N-1:0] exp, input string req);
    for (int i = 0; i < N; i++) begin
      if (exp[i]) begin
        chk({req, " engReq"}, int'(engReq), 1);
        chk({req, " engSector"}, int'(engSector), i);
        engDone = 1'b1;
        tick();
        engDone = 1'b0;
      end
    end
    chk({req, " busy after last done"}, int'(busy), 0);
  endtask

  // queue sel (strobes highest index first), expire, check outcome
  task automatic runSeq(input logic [N-1:0] sel, input logic [N-1:0] prot);
    logic [N-1:0] eff;
    int nLeft;
    eff = sel & ~prot;
    protMask = prot;
    nLeft = $countones(sel);
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) begin
        strobe(i);
        nLeft--;
        if (nLeft > 0) begin
          repeat (GAP) tick();
          chk("R3 window restarted", int'(windowExpired), 0);
        end
      end
    end
    repeat (W - 1) tick();
    chk("R2 window still open", int'(windowExpired), 0);
    chk("R2 busy in window", int'(busy), 1);
    tick();
    chk("R8 expired", int'(windowExpired), 1);
    if (eff == '0) begin
      repeat (H - 1) tick();
      chk("R7 no request", int'(engReq), 0);
      chk("R7 busy during hold", int'(busy), 1);
      tick();
      chk("R7 idle after hold", int'(busy), 0);
      chk("R8 status low when idle", int'(windowExpired), 0);
    end else begin
      serve(eff, "R5 R6 order");
      chk("R8 status low when idle", int'(windowExpired), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 windowExpired", int'(windowExpired), 0);
    chk("R1 engReq", int'(engReq), 0);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 busy after release", int'(busy), 0);

    // vector table, R4: all orders and counts
    for (int v = 0; v < 4; v++) begin
      runSeq(SEL_V[v], PROT_V[v]);
      tick();
    end

    // R4: invalid index ignored in idle
    protMask = '0;
    strobe(25);
    chk("R4 invalid index in idle", int'(busy), 0);

    // R4: invalid index in window does not restart it
    strobe(9);
    repeat (GAP) tick();
    strobe(31);
    tick();
    chk("R4 invalid index no restart", int'(windowExpired), 1);
    serve(19'h00200, "R4 only valid sector");

    // R9: abort in window, then R11 fresh queue
    strobe(3);
    strobe(12);
    abortStrobe = 1'b1;
    tick();
    abortStrobe = 1'b0;
    chk("R9 idle after abort", int'(busy), 0);
    // abort wins over select in the same cycle
    strobe(6);
    selStrobe = 1'b1; selIdx = 5'd7; abortStrobe = 1'b1;
    tick();
    selStrobe = 1'b0; abortStrobe = 1'b0;
    chk("R9 abort wins", int'(busy), 0);
    runSeq(19'h00020, '0);
    chk("R11 only new sector erased", int'(busy), 0);

    // R10: strobes ignored during erase
    strobe(5);
    repeat (W) tick();
    chk("R10 erasing sector 5", int'(engSector), 5);
    abortStrobe = 1'b1;
    tick();
    abortStrobe = 1'b0;
    chk("R10 abort ignored req", int'(engReq), 1);
    chk("R10 abort ignored sector", int'(engSector), 5);
    strobe(0);
    chk("R10 select ignored sector", int'(engSector), 5);
    engDone = 1'b1;
    tick();
    engDone = 1'b0;
    chk("R10 idle after single erase", int'(busy), 0);
    runSeq(19'h00080, '0);

    // R6: protection sampled at expiry, not at strobe
    protMask = 19'h00100;
    strobe(8);
    strobe(2);
    protMask = 19'h00004;
    repeat (W) tick();
    serve(19'h00100, "R6 sampled at expiry");

    // R11: reset empties a queue in the window
    protMask = '0;
    strobe(11);
    rstN = 1'b0;
    tick();
    chk("R11 reset idle", int'(busy), 0);
    rstN = 1'b1;
    tick();
    runSeq(19'h00002, '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule